// File: doc/BRIEF.md
# Cascadable Dual Timer/Counter Pair

Two 16-bit count channels, A and B, sit behind a small synchronous register interface. Each channel has a configuration word, a write-only command word, a period (reload) register and a live count. A channel runs in one of two modes. In timer mode it steps on a prescaled internal strobe, or on every cycle in which its external input is active. In counter mode it steps on chosen edges of its external input, which can be inverted and passed through a two-flop synchroniser. A channel counts up or down, and either reloads its period on expiry or stops after a single expiry. Each expiry sets a sticky status bit. The status bit, masked by an enable bit, drives an interrupt line.

Setting the join bit in channel A's configuration makes the two channels one 32-bit timer. A's configuration and commands control it, and its period, count and expiry appear through channel A's addresses and status bit. While the channels are joined, configuration and command writes to channel B are dropped.

Registers are written with `wr_en_i`/`wr_addr_i`/`wr_data_i` and take effect on the next rising clock edge. `rd_data_o` is a combinational view of the register selected by `rd_addr_i`.

Top module: `tmr_pair_top`

## Requirements
- R1: After reset all counts, periods, configuration words, enables and status bits read zero, and `irq_o` is 0.
- R2: Command word (A at address 2, B at address 3): bit0 starts, bit1 stops, bit2 together with bit0 loads the count from the period register first. A start without bit2 resumes from the held count. A stop halts counting, and when bit0 and bit1 are written together the stop wins.
- R3: With bit1 of the configuration word clear (configuration at address 0 for A, address 1 for B), a running channel decrements once per counting event. An event at count zero is an expiry: the status bit is set and, with bit3 clear, the count reloads the period.
- R4: With bit1 set the channel increments. An event at the all-ones count is an expiry and reloads the period, as in R3.
- R5: With bit3 set, an expiry sets the count to zero and clears the running flag. Later events leave the count unchanged.
- R6: Counter mode is bit2=1. Bits 7:6 select the counted edge of the conditioned external input: 00 none, 01 rising, 10 falling, 11 both. Bit10=1 counts the internal strobe `tick_i` instead of the input.
- R7: Bit5 inverts the external input before edge detection, so rising-edge mode then counts falling transitions of the pin.
- R8: With bit8 clear, an input change is counted at the first rising clock edge after it. With bit8 set, it is counted at the third.
- R9: In timer mode (bit2=0), bit9=1 makes the channel count every cycle in which the conditioned external input is high. Bit9=0 makes it count `tick_i`.
- R10: Bit4 of A's configuration joins the channels. A's period write (address 4) then loads all 32 bits, A's count read (address 6) returns all 32 bits, and the joint expiry sets status bit 0 only.
- R11: While the channels are joined, writes to B's configuration and command words have no effect.
- R12: Status (address 9, bit0 A, bit1 B) is cleared by writing 1. `irq_o[i]` is status bit i AND enable bit i (address 8). An expiry that falls in the same cycle as a clear leaves the bit set.
- R13: Bit0 of a configuration read is the read-only running flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Prescaled internal count strobe, one cycle per step |
| ext_i | input | 2 | External inputs, bit0 for A, bit1 for B |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 4 | Register read address |
| rd_data_o | output | 32 | Read data for `rd_addr_i` |
| irq_o | output | 2 | Interrupt requests, bit0 A, bit1 B |

## Verification
The bench checks the expiry boundaries in both directions: a design with an off-by-one compare shows a period one step too long or too short. It also checks that a carry ripples from the low half into the high half while the channels are joined; a design that kept the two halves apart would wrap at 16 bits. It checks the synchroniser latency cycle by cycle, the drop of B commands while joined, and a status clear that lands in the same cycle as an expiry. A design that let the clear win would lose that interrupt. Random periods and event counts, with expected counts computed in the bench, cover the cyclic reload arithmetic.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 4;
  localparam int NCH    = 2;
  localparam int CTL_W  = 11;

  typedef enum logic [ADDR_W-1:0] {
    ADR_CTL_A = 4'd0, ADR_CTL_B = 4'd1,
    ADR_RUN_A = 4'd2, ADR_RUN_B = 4'd3,
    ADR_REL_A = 4'd4, ADR_REL_B = 4'd5,
    ADR_CNT_A = 4'd6, ADR_CNT_B = 4'd7,
    ADR_IEN   = 4'd8, ADR_STAT  = 4'd9
  } reg_addr_e;

  // configuration bits 10:1 (bit 0 is the running flag on read)
  typedef struct packed {
    logic       csrc;     // counter mode: 1 = internal strobe
    logic       text;     // timer mode: 1 = external level gate
    logic       sync;     // two-flop input synchroniser
    logic [1:0] edge_sel; // 00 none, 01 rise, 10 fall, 11 both
    logic       inv;      // invert external input
    logic       cas;      // join A and B (channel A only)
    logic       once;     // stop after one expiry
    logic       cnt;      // 1 = counter mode
    logic       up;       // 1 = count up
  } ctl_t;
endpackage

// File: rtl/tmr_evt.sv
module tmr_evt (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_i,
  input  logic       tick_i,
  input  logic       sync_i,
  input  logic       inv_i,
  input  logic [1:0] edge_i,
  input  logic       cnt_i,
  input  logic       text_i,
  input  logic       csrc_i,
  output logic       evt_o
);
  logic [1:0] sync_q, sync_d;
  logic       prev_q, lvl, edge_hit;

  always_comb begin
    sync_d = {sync_q[0], ext_i};
    lvl    = (sync_i ? sync_q[1] : ext_i) ^ inv_i;
    unique case (edge_i)
      2'b01:   edge_hit = lvl & ~prev_q;
      2'b10:   edge_hit = ~lvl & prev_q;
      2'b11:   edge_hit = lvl ^ prev_q;
      default: edge_hit = 1'b0;
    endcase
    evt_o = cnt_i ? (csrc_i ? tick_i : edge_hit) : (text_i ? lvl : tick_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= lvl;
    end
  end

  // R8
  sync_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> sync_q[1] == $past(sync_q[0]));
endmodule

// File: rtl/tmr_engine.sv
module tmr_engine #(
  parameter int CW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cas_i,
  input  logic [1:0]      up_i,
  input  logic [1:0]      once_i,
  input  logic [1:0]      evt_i,
  input  logic [1:0]      start_i,
  input  logic [1:0]      stop_i,
  input  logic [1:0]      load_i,
  input  logic [2*CW-1:0] rel_i,
  output logic [2*CW-1:0] cnt_o,
  output logic [1:0]      run_o,
  output logic [1:0]      exp_o
);
  localparam int DW = 2 * CW;

  logic [DW-1:0] cnt_q, cnt_d, a_cur, a_lim, a_rel, a_nxt;
  logic [CW-1:0] b_cur, b_nxt;
  logic [1:0]    run_q, run_d;
  logic          a_end, b_end;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    exp_o = '0;
    a_lim = cas_i ? {DW{1'b1}} : {{CW{1'b0}}, {CW{1'b1}}};
    a_cur = cas_i ? cnt_q : {{CW{1'b0}}, cnt_q[CW-1:0]};
    a_rel = cas_i ? rel_i : {{CW{1'b0}}, rel_i[CW-1:0]};
    a_end = up_i[0] ? (a_cur == a_lim) : (a_cur == '0);
    a_nxt = a_end ? (once_i[0] ? '0 : a_rel)
                  : (up_i[0] ? a_cur + 1'b1 : a_cur - 1'b1);
    b_cur = cnt_q[DW-1:CW];
    b_end = up_i[1] ? (&b_cur) : (b_cur == '0);
    b_nxt = b_end ? (once_i[1] ? '0 : rel_i[DW-1:CW])
                  : (up_i[1] ? b_cur + 1'b1 : b_cur - 1'b1);

    if (stop_i[0]) begin
      run_d[0] = 1'b0;
    end else if (start_i[0]) begin
      run_d[0] = 1'b1;
      if (load_i[0]) cnt_d = cas_i ? rel_i : {cnt_q[DW-1:CW], rel_i[CW-1:0]};
    end else if (run_q[0] && evt_i[0]) begin
      exp_o[0] = a_end;
      cnt_d    = cas_i ? a_nxt : {cnt_q[DW-1:CW], a_nxt[CW-1:0]};
      if (a_end && once_i[0]) run_d[0] = 1'b0;
    end

    if (!cas_i) begin
      if (stop_i[1]) begin
        run_d[1] = 1'b0;
      end else if (start_i[1]) begin
        run_d[1] = 1'b1;
        if (load_i[1]) cnt_d[DW-1:CW] = rel_i[DW-1:CW];
      end else if (run_q[1] && evt_i[1]) begin
        exp_o[1]       = b_end;
        cnt_d[DW-1:CW] = b_nxt;
        if (b_end && once_i[1]) run_d[1] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign cnt_o = cnt_q;
  assign run_o = run_q;

  // R2
  stop_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i[0] |=> !run_q[0]);
  // R13
  run_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q[0]) |-> $past(start_i[0]));
  // R3
  down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q[0] && evt_i[0] && !start_i[0] && !stop_i[0] && !up_i[0] && !cas_i
     && cnt_q[CW-1:0] != '0) |=> cnt_q[CW-1:0] == $past(cnt_q[CW-1:0]) - 1'b1);
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set_i,
  input  logic           clr_we_i,
  input  logic           ien_we_i,
  input  logic [NCH-1:0] wdata_i,
  output logic [NCH-1:0] stat_o,
  output logic [NCH-1:0] ien_o,
  output logic [NCH-1:0] irq_o
);
  logic [NCH-1:0] stat_q, stat_d, ien_q;

  always_comb begin
    stat_d = (stat_q & ~(clr_we_i ? wdata_i : '0)) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      ien_q  <= '0;
    end else begin
      stat_q <= stat_d;
      if (ien_we_i) ien_q <= wdata_i;
    end
  end

  assign stat_o = stat_q;
  assign ien_o  = ien_q;
  assign irq_o  = stat_q & ien_q;

  // R12
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((stat_q & $past(set_i)) == $past(set_i)));
  // R12
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we_i |=> ((stat_q & $past(wdata_i & ~set_i)) == '0));
endmodule

// File: rtl/tmr_pair_top.sv
module tmr_pair_top
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [1:0]        ext_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [2*CW-1:0]   wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [2*CW-1:0]   rd_data_o,
  output logic [1:0]        irq_o
);
  localparam int DW = 2 * CW;

  logic [1:0]     rst_ff;
  logic           rst_int;
  ctl_t           ctl_q [NCH];
  ctl_t           ctl_d [NCH];
  logic [NCH-1:0] ctl_we, run_we, evt, run_w, exp_w, stat_w, ien_w, up_w, once_w;
  logic [NCH-1:0] start_w, stop_w, load_w;
  logic [DW-1:0]  rel_q, cnt_w;
  logic [CW-1:0]  rel_hi_d;
  logic           rel_lo_we, rel_hi_we, cas, ctl_b_raw;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= '0;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_int = rst_ff[1];

  assign cas = ctl_q[0].cas;

  always_comb begin
    ctl_b_raw = wr_en_i && (wr_addr_i == ADR_CTL_B);
    ctl_we[0] = wr_en_i && (wr_addr_i == ADR_CTL_A);
    ctl_we[1] = ctl_b_raw && !cas;
    run_we[0] = wr_en_i && (wr_addr_i == ADR_RUN_A);
    run_we[1] = wr_en_i && (wr_addr_i == ADR_RUN_B) && !cas;
    ctl_d[0]  = ctl_t'(wr_data_i[CTL_W-1:1]);
    ctl_d[1]  = ctl_t'(wr_data_i[CTL_W-1:1]);
    ctl_d[1].cas = 1'b0;
    rel_lo_we = wr_en_i && (wr_addr_i == ADR_REL_A);
    rel_hi_we = (rel_lo_we && cas) || (wr_en_i && (wr_addr_i == ADR_REL_B));
    rel_hi_d  = rel_lo_we ? wr_data_i[DW-1:CW] : wr_data_i[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      rel_q <= '0;
    end else begin
      if (rel_lo_we) rel_q[CW-1:0]  <= wr_data_i[CW-1:0];
      if (rel_hi_we) rel_q[DW-1:CW] <= rel_hi_d;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_int) begin
      if (!rst_int)       ctl_q[g] <= '0;
      else if (ctl_we[g]) ctl_q[g] <= ctl_d[g];
    end

    assign start_w[g] = run_we[g] & wr_data_i[0];
    assign stop_w[g]  = run_we[g] & wr_data_i[1];
    assign load_w[g]  = run_we[g] & wr_data_i[2];
    assign up_w[g]    = ctl_q[g].up;
    assign once_w[g]  = ctl_q[g].once;

    tmr_evt u_evt (
      .clk    (clk),
      .rst_n  (rst_int),
      .ext_i  (ext_i[g]),
      .tick_i (tick_i),
      .sync_i (ctl_q[g].sync),
      .inv_i  (ctl_q[g].inv),
      .edge_i (ctl_q[g].edge_sel),
      .cnt_i  (ctl_q[g].cnt),
      .text_i (ctl_q[g].text),
      .csrc_i (ctl_q[g].csrc),
      .evt_o  (evt[g])
    );
  end

  tmr_engine #(.CW(CW)) u_eng (
    .clk     (clk),
    .rst_n   (rst_int),
    .cas_i   (cas),
    .up_i    (up_w),
    .once_i  (once_w),
    .evt_i   (evt),
    .start_i (start_w),
    .stop_i  (stop_w),
    .load_i  (load_w),
    .rel_i   (rel_q),
    .cnt_o   (cnt_w),
    .run_o   (run_w),
    .exp_o   (exp_w)
  );

  tmr_irq #(.NCH(NCH)) u_irq (
    .clk      (clk),
    .rst_n    (rst_int),
    .set_i    (exp_w),
    .clr_we_i (wr_en_i && (wr_addr_i == ADR_STAT)),
    .ien_we_i (wr_en_i && (wr_addr_i == ADR_IEN)),
    .wdata_i  (wr_data_i[NCH-1:0]),
    .stat_o   (stat_w),
    .ien_o    (ien_w),
    .irq_o    (irq_o)
  );

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      ADR_CTL_A: rd_data_o[CTL_W-1:0] = {ctl_q[0], run_w[0]};
      ADR_CTL_B: rd_data_o[CTL_W-1:0] = {ctl_q[1], run_w[1]};
      ADR_REL_A: rd_data_o = cas ? rel_q : {{CW{1'b0}}, rel_q[CW-1:0]};
      ADR_REL_B: rd_data_o[CW-1:0] = rel_q[DW-1:CW];
      ADR_CNT_A: rd_data_o = cas ? cnt_w : {{CW{1'b0}}, cnt_w[CW-1:0]};
      ADR_CNT_B: rd_data_o[CW-1:0] = cnt_w[DW-1:CW];
      ADR_IEN:   rd_data_o[NCH-1:0] = ien_w;
      ADR_STAT:  rd_data_o[NCH-1:0] = stat_w;
      default:   rd_data_o = '0;
    endcase
  end

  // R11
  cas_ctl_b_chk: assert property (@(posedge clk) disable iff (!rst_int)
    (cas && ctl_b_raw) |=> $stable(ctl_q[1]));
endmodule

// File: tb/tmr_pair_top_tb.sv
`timescale 1ns/1ps
module tmr_pair_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, tick, wr_en;
  logic [1:0]  ext, irq;
  logic [3:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  int          n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  tmr_pair_top dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .ext_i(ext),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic ticks(input int n);
    repeat (n) begin @(negedge clk); tick = 1'b1; end
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic pulses(input int ch, input int n);
    repeat (n) begin
      @(negedge clk); ext[ch] = 1'b1;
      @(negedge clk); ext[ch] = 1'b0;
    end
    @(negedge clk);
  endtask

  function automatic logic [31:0] exp_cnt(input bit up, input int r, input int k);
    if (up) return 32'(r + k % (65536 - r));
    return 32'(r - k % (r + 1));
  endfunction

  initial begin
    #(8ns * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; tick = 1'b0; ext = '0; wr_en = 1'b0;
    wr_addr = '0; wr_data = '0; rd_addr = '0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(4'd0, v); chk("R1 ctl A", v, 0);
    rd(4'd6, v); chk("R1 cnt A", v, 0);
    rd(4'd9, v); chk("R1 status", v, 0);
    chk("R1 irq", {30'd0, irq}, 0);

    // R2/R3 down cyclic
    wr(4'd0, 32'h0); wr(4'd4, 32'd5); wr(4'd2, 32'h5);
    rd(4'd6, v); chk("R2 load on start", v, 5);
    ticks(3); rd(4'd6, v); chk("R3 down step", v, 2);
    ticks(3); rd(4'd6, v); chk("R3 reload at expiry", v, 5);
    rd(4'd9, v); chk("R3 status set", v, 1);
    chk("R12 irq masked", {30'd0, irq}, 0);
    wr(4'd8, 32'h1); chk("R12 irq enabled", {30'd0, irq}, 1);
    wr(4'd9, 32'h1); rd(4'd9, v); chk("R12 w1c", v, 0);
    chk("R12 irq after clear", {30'd0, irq}, 0);

    // R2/R13 stop, resume, stop wins
    wr(4'd2, 32'h2); rd(4'd0, v); chk("R13 run flag low", v, 0);
    ticks(4); rd(4'd6, v); chk("R2 stopped holds", v, 5);
    wr(4'd2, 32'h1); rd(4'd0, v); chk("R13 run flag high", v, 1);
    ticks(2); rd(4'd6, v); chk("R2 resume", v, 3);
    wr(4'd2, 32'h3); rd(4'd0, v); chk("R2 stop wins", v, 0);

    // R4 up expiry
    wr(4'd0, 32'h2); wr(4'd4, 32'hFFFE); wr(4'd2, 32'h5);
    ticks(2); rd(4'd6, v); chk("R4 up wrap reload", v, 32'hFFFE);
    rd(4'd9, v); chk("R4 status", v, 1);
    wr(4'd9, 32'h3);

    // R5 one-shot
    wr(4'd2, 32'h2); wr(4'd0, 32'h8); wr(4'd4, 32'd2); wr(4'd2, 32'h5);
    ticks(5); rd(4'd6, v); chk("R5 count zero", v, 0);
    rd(4'd0, v); chk("R5 run cleared", v, 32'h8);
    rd(4'd9, v); chk("R5 status", v, 1);
    wr(4'd9, 32'h1); ticks(2); rd(4'd6, v); chk("R5 ignores events", v, 0);

    // R12 set beats clear in same cycle
    wr(4'd0, 32'h0); wr(4'd4, 32'd0); wr(4'd2, 32'h5);
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; wr_addr = 4'd9; wr_data = 32'h1;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    rd(4'd9, v); chk("R12 set wins", v, 1);
    wr(4'd9, 32'h1); rd(4'd9, v); chk("R12 clear alone", v, 0);
    wr(4'd2, 32'h2);

    // R6 edge selection on B
    wr(4'd5, 32'd0); wr(4'd1, 32'h46); wr(4'd3, 32'h5);
    pulses(1, 3); rd(4'd7, v); chk("R6 rising", v, 3);
    wr(4'd1, 32'h86); pulses(1, 2); rd(4'd7, v); chk("R6 falling", v, 5);
    wr(4'd1, 32'hC6); pulses(1, 2); rd(4'd7, v); chk("R6 both", v, 9);
    wr(4'd1, 32'h06); pulses(1, 2); rd(4'd7, v); chk("R6 none", v, 9);
    wr(4'd1, 32'h406); ticks(3); rd(4'd7, v); chk("R6 internal src", v, 12);

    // R7 invert
    wr(4'd3, 32'h2); wr(4'd1, 32'h66); wr(4'd3, 32'h1);
    @(negedge clk); ext[1] = 1'b1; repeat (2) @(negedge clk);
    rd(4'd7, v); chk("R7 pin rise ignored", v, 12);
    ext[1] = 1'b0; repeat (2) @(negedge clk);
    rd(4'd7, v); chk("R7 pin fall counted", v, 13);

    // R8 synchroniser latency
    wr(4'd3, 32'h2); wr(4'd1, 32'h146); wr(4'd3, 32'h1);
    @(negedge clk); ext[1] = 1'b1;
    @(negedge clk); rd(4'd7, v); chk("R8 sync edge1", v, 13);
    @(negedge clk); rd(4'd7, v); chk("R8 sync edge2", v, 13);
    @(negedge clk); rd(4'd7, v); chk("R8 sync edge3", v, 14);
    ext[1] = 1'b0; repeat (4) @(negedge clk);
    wr(4'd3, 32'h2); wr(4'd1, 32'h46); wr(4'd3, 32'h1);
    @(negedge clk); ext[1] = 1'b1;
    @(negedge clk); rd(4'd7, v); chk("R8 unsync edge1", v, 15);
    ext[1] = 1'b0; @(negedge clk);

    // R9 timer gated by external level
    wr(4'd3, 32'h2); wr(4'd1, 32'h202); wr(4'd3, 32'h1);
    @(negedge clk); ext[1] = 1'b1;
    repeat (4) @(negedge clk);
    ext[1] = 1'b0; @(negedge clk);
    rd(4'd7, v); chk("R9 level gate", v, 19);

    // R10/R11 joined 32-bit timer
    wr(4'd9, 32'h3);
    wr(4'd0, 32'h10); wr(4'd4, 32'h0001_0002); wr(4'd2, 32'h5);
    rd(4'd6, v); chk("R10 32-bit load", v, 32'h0001_0002);
    ticks(3); rd(4'd6, v); chk("R10 borrow into high half", v, 32'h0000_FFFF);
    rd(4'd1, v); chk("R11 ctl B before", v, 32'h203);
    wr(4'd1, 32'h46); rd(4'd1, v); chk("R11 ctl B write dropped", v, 32'h203);
    wr(4'd3, 32'h2); rd(4'd1, v); chk("R11 run B write dropped", v, 32'h203);
    wr(4'd4, 32'h1); wr(4'd2, 32'h5);
    ticks(2); rd(4'd6, v); chk("R10 joint reload", v, 1);
    rd(4'd9, v); chk("R10 status bit0 only", v, 1);
    wr(4'd2, 32'h2); wr(4'd0, 32'h0);

    // R3/R4 random periods and event counts
    for (int i = 0; i < 10; i++) begin
      bit up = i[0];
      int r  = up ? 65535 - int'($urandom % 100) : int'($urandom % 100);
      int k  = 1 + int'($urandom % 250);
      int per = up ? 65536 - r : r + 1;
      wr(4'd2, 32'h2); wr(4'd0, up ? 32'h2 : 32'h0); wr(4'd4, 32'(r));
      wr(4'd9, 32'h3); wr(4'd2, 32'h5);
      ticks(k);
      rd(4'd6, v); chk(up ? "R4 random count" : "R3 random count", v, exp_cnt(up, r, k));
      rd(4'd9, v); chk(up ? "R4 random status" : "R3 random status", v & 32'h1, (k >= per) ? 1 : 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule